// File: doc/BRIEF.md
# Spiking Crossbar Multiplex-Accumulate Unit

This block produces the synaptic input currents and output spikes of a small group of spiking neurons with no multiplier anywhere in the datapath. Every input spike is a single bit, so a weight is simply passed or blocked by its spike. The weights that survive this selection are summed into per-neuron membrane accumulators by a wide adder split into independent signed lanes, one lane per neuron. The current added to neuron j over a timestep is therefore the sum, over all inputs k that spiked, of the weight W(k,j).

A timestep has three phases that share one set of membrane registers. In the accumulate phase the block takes beats over a valid/ready handshake. Each beat carries a spike vector and a packed weight word with one signed 8-bit weight per (input, neuron) pair. When the step-end strobe arrives, one threshold cycle fires every neuron whose membrane has reached the programmable threshold and clears those membranes. One leak cycle then shifts the remaining membranes right arithmetically by a programmable amount, and the block returns to accumulation. The spike vector is presented with a one-cycle valid. The membrane values are brought out so that downstream logic can observe them.

Top module: `scm_crossbar_mac`

## Requirements
- R1: While reset is asserted and right after it, in_ready is 1, out_valid is 0 and every membrane lane reads 0.
- R2: An accepted beat adds weight W(k,j) into lane j only when in_spikes[k] is 1. Weights whose spike bit is 0 have no effect. W(k,j) is in_weights[(k*LANES+j)*8 +: 8], two's complement.
- R3: Each lane is a 16-bit signed accumulator, lane j at membrane[j*16 +: 16]. The sum in one lane never carries into or borrows from a neighbouring lane.
- R4: A lane result above 32767 is held at 32767 and one below -32768 is held at -32768. The lane never wraps.
- R5: in_ready is 1 only in the accumulate phase. Beats offered while it is 0 change no membrane.
- R6: A step_end pulse in the accumulate phase drops in_ready on the next cycle. The threshold phase lasts one cycle and the leak phase one cycle, and then in_ready returns.
- R7: In the threshold cycle, neuron j fires when its signed membrane is greater than or equal to the signed threshold, equality included. A fired membrane becomes 0.
- R8: In the leak cycle, each neuron that did not fire has its membrane shifted arithmetically right by leak_shift, which rounds toward minus infinity.
- R9: out_valid is high for exactly one cycle per timestep, the cycle after the threshold cycle. out_spikes[j] is 1 there for each neuron j that fired, and out_spikes is 0 whenever out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Spike/weight beat offered |
| in_ready | output | 1 | Beat accepted this cycle when in_valid is also 1 |
| in_spikes | input | N_IN | Binary input spikes of the beat |
| in_weights | input | N_IN*LANES*WW | Packed signed weights, input-major |
| step_end | input | 1 | Ends accumulation for this timestep |
| threshold | input | AW | Signed firing threshold |
| leak_shift | input | SHW | Arithmetic right-shift amount for leak |
| out_valid | output | 1 | Output spike vector valid |
| out_spikes | output | LANES | Fired neurons of the timestep |
| membrane | output | LANES*AW | Current membrane values, lane-packed |

## Verification
Within each timestep, every one of the four spike patterns of the two inputs is applied with fresh pseudo-random weights. This separates correct gating from a swapped input, an inverted spike or a weight that always passes. Weights of mixed sign in neighbouring lanes expose any carry or borrow that leaks across a lane edge. A long run of maximum positive and maximum negative weights drives lanes to both saturation limits. The threshold is then set exactly at the saturated value to test the equality case, and the leak is applied to a negative value. Threshold and shift are varied across timesteps, and junk beats are offered during the threshold and leak cycles to show that they are ignored.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [1:0] {
    PH_ACC  = 2'd0,
    PH_THR  = 2'd1,
    PH_LEAK = 2'd2
  } phase_t;
endpackage

// File: rtl/scm_spike_gate.sv
module scm_spike_gate #(
  parameter int N_IN  = 2,
  parameter int LANES = 4,
  parameter int WW    = 8
) (
  input  logic [N_IN-1:0]          spikes,
  input  logic [N_IN*LANES*WW-1:0] weights,
  output logic [N_IN*LANES*WW-1:0] gated
);
  localparam int ROW_W = LANES * WW;

  // A binary spike selects its weight row or forces it to zero
  for (genvar k = 0; k < N_IN; k++) begin : g_row
    assign gated[k*ROW_W +: ROW_W] = spikes[k] ? weights[k*ROW_W +: ROW_W] : '0;
  end
endmodule

// File: rtl/scm_simd_adder.sv
module scm_simd_adder #(
  parameter int N_IN  = 2,
  parameter int LANES = 4,
  parameter int WW    = 8,
  parameter int AW    = 16
) (
  input  logic [LANES*AW-1:0]      acc_in,
  input  logic [N_IN*LANES*WW-1:0] gated,
  output logic [LANES*AW-1:0]      acc_out
);
  localparam int SW = AW + $clog2(N_IN + 1) + 1;
  localparam logic signed [SW-1:0] MAXV = SW'((2 ** (AW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  // Each lane has its own wide sum; no carry path exists between lanes
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic signed [SW-1:0] tot;
    logic        [WW-1:0] w;
    logic        [AW-1:0] a;

    always_comb begin
      a   = acc_in[j*AW +: AW];
      tot = {{(SW-AW){a[AW-1]}}, a};
      w   = '0;
      for (int k = 0; k < N_IN; k++) begin
        w   = gated[(k*LANES + j)*WW +: WW];
        tot = tot + {{(SW-WW){w[WW-1]}}, w};
      end
    end

    always_comb begin
      if (tot > MAXV)      acc_out[j*AW +: AW] = MAXV[AW-1:0];
      else if (tot < MINV) acc_out[j*AW +: AW] = MINV[AW-1:0];
      else                 acc_out[j*AW +: AW] = tot[AW-1:0];
    end
  end
endmodule

// File: rtl/scm_phase_ctrl.sv
module scm_phase_ctrl
  import scm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic step_end,
  output logic in_ready,
  output logic accept,
  output logic thr_phase,
  output logic leak_phase
);
  phase_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_ACC:  if (step_end) state_d = PH_THR;
      PH_THR:  state_d = PH_LEAK;
      PH_LEAK: state_d = PH_ACC;
      default: state_d = PH_ACC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_ACC;
    else        state_q <= state_d;
  end

  assign in_ready   = (state_q == PH_ACC);
  assign accept     = in_valid && in_ready;
  assign thr_phase  = (state_q == PH_THR);
  assign leak_phase = (state_q == PH_LEAK);

  AST_STEP_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && step_end) |=> !in_ready); // R6
  AST_LEAK_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    leak_phase |=> in_ready); // R6
endmodule

// File: rtl/scm_crossbar_mac.sv
module scm_crossbar_mac #(
  parameter int N_IN  = 2,
  parameter int LANES = 4,
  parameter int WW    = 8,
  parameter int AW    = 16,
  localparam int SHW  = $clog2(AW)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N_IN-1:0]          in_spikes,
  input  logic [N_IN*LANES*WW-1:0] in_weights,
  input  logic                     step_end,
  input  logic [AW-1:0]            threshold,
  input  logic [SHW-1:0]           leak_shift,
  output logic                     out_valid,
  output logic [LANES-1:0]         out_spikes,
  output logic [LANES*AW-1:0]      membrane
);
  logic accept, thr_phase, leak_phase;
  logic [N_IN*LANES*WW-1:0] gated;
  logic [LANES*AW-1:0]      sum_flat;
  logic signed [AW-1:0]     mem_q [LANES];
  logic signed [AW-1:0]     mem_d [LANES];
  logic [LANES-1:0]         fire_now, spk_q, zero_mask;
  logic                     ov_q;

  scm_phase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .step_end(step_end),
    .in_ready(in_ready), .accept(accept),
    .thr_phase(thr_phase), .leak_phase(leak_phase)
  );

  scm_spike_gate #(.N_IN(N_IN), .LANES(LANES), .WW(WW)) u_gate (
    .spikes(in_spikes), .weights(in_weights), .gated(gated)
  );

  scm_simd_adder #(.N_IN(N_IN), .LANES(LANES), .WW(WW), .AW(AW)) u_add (
    .acc_in(membrane), .gated(gated), .acc_out(sum_flat)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign membrane[j*AW +: AW] = mem_q[j];
    assign fire_now[j]  = (mem_q[j] >= $signed(threshold));
    assign zero_mask[j] = (mem_q[j] == '0);
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      mem_d[j] = mem_q[j];
      if (accept)
        mem_d[j] = $signed(sum_flat[j*AW +: AW]);
      else if (thr_phase && fire_now[j])
        mem_d[j] = '0;
      else if (leak_phase && !spk_q[j])
        mem_d[j] = mem_q[j] >>> leak_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < LANES; j++) mem_q[j] <= '0;
    end else if (accept || thr_phase || leak_phase) begin
      for (int j = 0; j < LANES; j++) mem_q[j] <= mem_d[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spk_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      ov_q <= thr_phase;
      if (thr_phase) spk_q <= fire_now;
    end
  end

  assign out_valid  = ov_q;
  assign out_spikes = ov_q ? spk_q : '0;

  AST_SILENT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_spikes == '0) |=> membrane == $past(membrane)); // R2
  AST_NO_INPUT_WHILE_FIRING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R5
  AST_FIRED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_spikes & ~zero_mask) == '0)); // R7
  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R9
  AST_QUIET_SPIKES: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_spikes == '0); // R9
endmodule

// File: tb/scm_crossbar_mac_test.sv
`timescale 1ns/1ps
module scm_crossbar_mac_test;
  localparam int N_IN = 2, LANES = 4, WW = 8, AW = 16;

  logic clk, rst_n, in_valid, step_end, in_ready, out_valid;
  logic [N_IN-1:0] in_spikes;
  logic [N_IN*LANES*WW-1:0] in_weights;
  logic [AW-1:0] threshold;
  logic [3:0] leak_shift;
  logic [LANES-1:0] out_spikes;
  logic [LANES*AW-1:0] membrane;

  int tests, fails;
  int mem_m [LANES];
  logic [31:0] seed;

  scm_crossbar_mac uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_spikes(in_spikes), .in_weights(in_weights), .step_end(step_end),
    .threshold(threshold), .leak_shift(leak_shift), .out_valid(out_valid),
    .out_spikes(out_spikes), .membrane(membrane)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [AW*LANES-1:0] exp_mem();
    logic [AW*LANES-1:0] v;
    for (int j = 0; j < LANES; j++) v[j*AW +: AW] = mem_m[j][AW-1:0];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
  endtask

  // starts and ends just after a falling edge
  task automatic beat(input logic [N_IN-1:0] spk, input logic [N_IN*LANES*WW-1:0] w, input string req);
    in_valid = 1'b1; in_spikes = spk; in_weights = w;
    check(in_ready == 1'b1, "R5", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      int s;
      s = mem_m[j];
      for (int k = 0; k < N_IN; k++)
        if (spk[k]) s += int'($signed(w[(k*LANES + j)*WW +: WW]));
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      mem_m[j] = s;
    end
    check(membrane == exp_mem(), req, membrane, exp_mem());
  endtask

  task automatic end_step(input logic [AW-1:0] thr, input logic [3:0] sh);
    logic [LANES-1:0] fx;
    threshold = thr; leak_shift = sh;
    for (int j = 0; j < LANES; j++) fx[j] = (mem_m[j] >= int'($signed(thr)));
    step_end = 1'b1;
    @(negedge clk);
    step_end = 1'b0;
    check(in_ready == 1'b0, "R6", 64'(in_ready), 64'd0);
    check(out_valid == 1'b0 && out_spikes == '0, "R9", 64'(out_valid), 64'd0);
    in_valid = 1'b1; in_spikes = '1; in_weights = {8{8'h7f}};
    @(negedge clk);
    check(in_ready == 1'b0, "R5", 64'(in_ready), 64'd0);
    check(out_valid == 1'b1, "R9", 64'(out_valid), 64'd1);
    check(out_spikes == fx, "R7", 64'(out_spikes), 64'(fx));
    for (int j = 0; j < LANES; j++) begin
      if (fx[j]) mem_m[j] = 0;
      else       mem_m[j] = mem_m[j] >>> sh;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0 && out_spikes == '0, "R9", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R6", 64'(in_ready), 64'd1);
    check(membrane == exp_mem(), "R8", membrane, exp_mem());
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N_IN*LANES*WW-1:0] w;
    logic [AW-1:0] thr;
    tests = 0; fails = 0; seed = 32'h1234_5678;
    for (int j = 0; j < LANES; j++) mem_m[j] = 0;
    rst_n = 1'b0; in_valid = 1'b0; step_end = 1'b0; in_spikes = '0;
    in_weights = '0; threshold = '0; leak_shift = '0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", {in_ready, out_valid}, 64'h2);
    check(membrane == '0, "R1", membrane, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(membrane == '0 && out_valid == 1'b0, "R1", membrane, 64'd0);

    // spike pattern sweep, mixed-sign lanes, varied threshold and leak (R2, R3)
    for (int step = 0; step < 40; step++) begin
      for (int p = 0; p < 4; p++) begin
        for (int q = 0; q < 2; q++) begin
          rnd(); w[q*32 +: 32] = seed;
        end
        beat(2'(p), w, (p == 3) ? "R3" : "R2");
      end
      rnd();
      thr = AW'(int'(seed[9:0]) - 512);
      end_step(thr, 4'(step));
    end

    // lane isolation: +1 next to -1 across every lane edge (R3)
    beat(2'b01, {8'hff, 8'h01, 8'hff, 8'h01, 8'h01, 8'hff, 8'h01, 8'hff}, "R3");
    beat(2'b10, {8'h80, 8'h7f, 8'h80, 8'h7f, 8'h00, 8'h00, 8'h00, 8'h00}, "R3");

    // drive to both saturation limits (R4)
    for (int i = 0; i < 140; i++)
      beat(2'b11, {8'h80, 8'h80, 8'h7f, 8'h7f, 8'h80, 8'h80, 8'h7f, 8'h7f}, "R4");
    check(membrane == {16'h8000, 16'h8000, 16'h7fff, 16'h7fff}, "R4", membrane,
          {16'h8000, 16'h8000, 16'h7fff, 16'h7fff});
    // threshold equal to saturated value fires; negative lanes leak by 3 (R7, R8)
    end_step(16'h7fff, 4'd3);
    check(membrane == {16'hf000, 16'hf000, 16'h0000, 16'h0000}, "R8", membrane,
          {16'hf000, 16'hf000, 16'h0000, 16'h0000});

    // silent beat with nonzero weights changes nothing (R2)
    beat(2'b00, {8{8'h55}}, "R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule